// File: doc/BRIEF.md
# Broadcast and Multicast Storm Limiter

This block limits how many broadcast and multicast frames each receive port may accept during a fixed measurement window. One programmable interval timer, shared by every port, divides the core clock into equal windows. Each port holds two 8-bit budgets, one for broadcast frames and one for multicast frames. Within a window, a port accepts frames of a class until that class's budget is spent, and it drops every further frame of that class until the next window opens.

Every port presents a one-cycle arrival strobe per frame, together with broadcast and multicast qualifiers that an upstream classifier has already worked out. In the same cycle, the block returns a drop decision for that port. A global enable switches the whole function on or off. While the enable is low, nothing is dropped and all state is kept cleared.

Programming the interval to one millisecond gives a rate scale of 1000 frames per second per budget unit. A budget of 1 then allows 1000 frames per second, and a budget of 255 allows 255000.

Top module: `storm_limiter`

## Requirements
- R1: After synchronous reset, the interval timer and every budget counter are zero, and the first qualifying frame of any port is accepted.
- R2: While enabled, a window lasts exactly max(prescale_cfg, 16) clock cycles, counted from the first enabled cycle. In the last cycle of each window, every port's counters restart for the following window.
- R3: A prescale_cfg value below 16 (0x10) acts as 16.
- R4: Port p's broadcast budget is bcast_limit[p*8 +: 8] and its multicast budget is mcast_limit[p*8 +: 8]. Within a window, the first L frames of a class are accepted, and later frames of that class are dropped while the count is at or above L. A dropped frame does not add to the count.
- R5: A budget of 0 disables limiting for that port and class, so such frames are never dropped.
- R6: While limit_en is 0, no frame is dropped and the timer and counters are held at zero. Raising limit_en starts a fresh window with full budgets.
- R7: A frame that arrives in the last cycle of a window is charged to the new window, so with a nonzero budget it is accepted.
- R8: A frame with both qualifiers set is charged to the broadcast budget. A frame with neither qualifier is never dropped and is charged to no budget.
- R9: Budgets are independent across ports, and between the two classes of one port.
- R10: frame_drop[p] is combinational with the strobe. It can be 1 only in a cycle where frame_valid[p] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| limit_en | input | 1 | Global enable of the limiting function |
| prescale_cfg | input | 19 | Window length in clock cycles (minimum 16) |
| bcast_limit | input | NUM_PORTS*8 | Per-port broadcast budgets, port p at [p*8 +: 8] |
| mcast_limit | input | NUM_PORTS*8 | Per-port multicast budgets, port p at [p*8 +: 8] |
| frame_valid | input | NUM_PORTS | Per-port one-cycle frame arrival strobe |
| frame_bcast | input | NUM_PORTS | Frame is broadcast |
| frame_mcast | input | NUM_PORTS | Frame is multicast |
| frame_drop | output | NUM_PORTS | Drop decision for the arriving frame |

## Verification
The assertions check cycle-local properties on every cycle:
- a drop never occurs without a strobe, while the block is disabled, for a frame with no qualifier, or against a zero budget;
- a frame in a window's closing cycle is never dropped;
- the timer never closes a window shorter than 16 cycles and stays silent while disabled.

The exact number of frames accepted per window, the window length for a given setting, and the independence of ports and classes all depend on history across many cycles. Only the bench's reference model and its directed scenarios can show these.

// File: rtl/storm_limiter_pkg.sv
package storm_limiter_pkg;

    localparam int SL_PRESCALE_W   = 19;
    localparam int SL_LIMIT_W      = 8;
    localparam int SL_MIN_PRESCALE = 16;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_BCAST = 2'd1,
        CLS_MCAST = 2'd2
    } sl_class_e;

    typedef struct packed {
        logic valid;
        logic bcast;
        logic mcast;
    } sl_frame_t;

    // Broadcast outranks multicast; an unqualified frame has no budget.
    function automatic sl_class_e sl_classify(input sl_frame_t f);
        if (!f.valid)
            return CLS_NONE;
        else if (f.bcast)
            return CLS_BCAST;
        else if (f.mcast)
            return CLS_MCAST;
        else
            return CLS_NONE;
    endfunction

    // Budget class handled by counter slot c of a port.
    function automatic sl_class_e sl_slot_class(input int c);
        return (c == 0) ? CLS_BCAST : CLS_MCAST;
    endfunction

endpackage

// File: rtl/sl_interval_timer.sv
module sl_interval_timer #(
    parameter int PRESCALE_W   = storm_limiter_pkg::SL_PRESCALE_W,
    parameter int MIN_PRESCALE = storm_limiter_pkg::SL_MIN_PRESCALE
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic [PRESCALE_W-1:0] prescale_cfg,
    output logic                  tick
);
    localparam logic [PRESCALE_W-1:0] FLOOR = PRESCALE_W'(MIN_PRESCALE);

    logic [PRESCALE_W-1:0] span;
    logic [PRESCALE_W-1:0] count_q;

    // Programmed values below the floor are raised to it.
    always_comb begin
        span = (prescale_cfg < FLOOR) ? FLOOR : prescale_cfg;
        // Compare with >= so that lowering the span mid-window still closes it.
        tick = enable && (count_q >= (span - PRESCALE_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst || !enable)
            count_q <= '0;
        else if (tick)
            count_q <= '0;
        else
            count_q <= count_q + PRESCALE_W'(1);
    end

endmodule

// File: rtl/sl_budget_counter.sv
module sl_budget_counter #(
    parameter int LIMIT_W = storm_limiter_pkg::SL_LIMIT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               restart,
    input  logic               hit,
    input  logic [LIMIT_W-1:0] limit,
    output logic               drop
);
    logic [LIMIT_W-1:0] used_q;
    logic               limited;
    logic               spent;
    logic               charge;

    always_comb begin
        limited = (limit != '0);
        // In the restart cycle the budget is already full again.
        spent   = limited && !restart && (used_q >= limit);
        drop    = enable && hit && spent;
        charge  = enable && hit && limited && !spent;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable)
            used_q <= '0;
        else if (restart)
            used_q <= charge ? LIMIT_W'(1) : '0;
        else if (charge)
            used_q <= used_q + LIMIT_W'(1);
    end

endmodule

// File: rtl/sl_port_limiter.sv
module sl_port_limiter
    import storm_limiter_pkg::*;
#(
    parameter int LIMIT_W = SL_LIMIT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               restart,
    input  sl_frame_t          frame,
    input  logic [LIMIT_W-1:0] bcast_budget,
    input  logic [LIMIT_W-1:0] mcast_budget,
    output logic               drop
);
    localparam int NUM_CLASSES = 2;

    sl_class_e          cls;
    logic [LIMIT_W-1:0] budget [NUM_CLASSES];
    logic [NUM_CLASSES-1:0] slot_hit;
    logic [NUM_CLASSES-1:0] slot_drop;

    always_comb begin
        cls       = sl_classify(frame);
        budget[0] = bcast_budget;
        budget[1] = mcast_budget;
    end

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_slot
        assign slot_hit[c] = (cls == sl_slot_class(c));

        sl_budget_counter #(
            .LIMIT_W (LIMIT_W)
        ) u_budget (
            .clk     (clk),
            .rst     (rst),
            .enable  (enable),
            .restart (restart),
            .hit     (slot_hit[c]),
            .limit   (budget[c]),
            .drop    (slot_drop[c])
        );
    end

    assign drop = |slot_drop;

endmodule

// File: rtl/storm_limiter.sv
module storm_limiter
    import storm_limiter_pkg::*;
#(
    parameter int NUM_PORTS    = 4,
    parameter int PRESCALE_W   = SL_PRESCALE_W,
    parameter int LIMIT_W      = SL_LIMIT_W,
    parameter int MIN_PRESCALE = SL_MIN_PRESCALE
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         limit_en,
    input  logic [PRESCALE_W-1:0]        prescale_cfg,
    input  logic [NUM_PORTS*LIMIT_W-1:0] bcast_limit,
    input  logic [NUM_PORTS*LIMIT_W-1:0] mcast_limit,
    input  logic [NUM_PORTS-1:0]         frame_valid,
    input  logic [NUM_PORTS-1:0]         frame_bcast,
    input  logic [NUM_PORTS-1:0]         frame_mcast,
    output logic [NUM_PORTS-1:0]         frame_drop
);
    logic window_tick;

    sl_interval_timer #(
        .PRESCALE_W   (PRESCALE_W),
        .MIN_PRESCALE (MIN_PRESCALE)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .enable       (limit_en),
        .prescale_cfg (prescale_cfg),
        .tick         (window_tick)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        sl_frame_t frm;

        assign frm = '{valid: frame_valid[p],
                       bcast: frame_bcast[p],
                       mcast: frame_mcast[p]};

        sl_port_limiter #(
            .LIMIT_W (LIMIT_W)
        ) u_port (
            .clk          (clk),
            .rst          (rst),
            .enable       (limit_en),
            .restart      (window_tick),
            .frame        (frm),
            .bcast_budget (bcast_limit[p*LIMIT_W +: LIMIT_W]),
            .mcast_budget (mcast_limit[p*LIMIT_W +: LIMIT_W]),
            .drop         (frame_drop[p])
        );
    end

endmodule

// File: rtl/storm_limiter_checker.sv
module storm_limiter_checker #(
    parameter int NUM_PORTS    = 4,
    parameter int PRESCALE_W   = 19,
    parameter int LIMIT_W      = 8,
    parameter int MIN_PRESCALE = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         limit_en,
    input logic [NUM_PORTS*LIMIT_W-1:0] bcast_limit,
    input logic [NUM_PORTS*LIMIT_W-1:0] mcast_limit,
    input logic [NUM_PORTS-1:0]         frame_valid,
    input logic [NUM_PORTS-1:0]         frame_bcast,
    input logic [NUM_PORTS-1:0]         frame_mcast,
    input logic [NUM_PORTS-1:0]         frame_drop,
    input logic                         window_tick
);
    localparam int GW = PRESCALE_W + 1;
    localparam logic [GW-1:0] GAP_MAX = {GW{1'b1}};

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || !limit_en || window_tick)
            gap_q <= '0;
        else if (gap_q != GAP_MAX)
            gap_q <= gap_q + GW'(1);
    end

    assert_drop_needs_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        (frame_drop & ~frame_valid) == '0);

    assert_no_drop_when_off_R6: assert property (@(posedge clk) disable iff (rst)
        !limit_en |-> (frame_drop == '0));

    assert_timer_quiet_when_off_R6: assert property (@(posedge clk) disable iff (rst)
        !limit_en |-> !window_tick);

    assert_min_window_R3: assert property (@(posedge clk) disable iff (rst)
        window_tick |-> (gap_q >= GW'(MIN_PRESCALE - 1)));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        logic [LIMIT_W-1:0] bl;
        logic [LIMIT_W-1:0] ml;
        assign bl = bcast_limit[p*LIMIT_W +: LIMIT_W];
        assign ml = mcast_limit[p*LIMIT_W +: LIMIT_W];

        assert_plain_frame_passes_R8: assert property (@(posedge clk) disable iff (rst)
            (frame_valid[p] && !frame_bcast[p] && !frame_mcast[p]) |-> !frame_drop[p]);

        assert_zero_bcast_budget_R5: assert property (@(posedge clk) disable iff (rst)
            (frame_valid[p] && frame_bcast[p] && bl == '0) |-> !frame_drop[p]);

        assert_zero_mcast_budget_R5: assert property (@(posedge clk) disable iff (rst)
            (frame_valid[p] && !frame_bcast[p] && frame_mcast[p] && ml == '0) |-> !frame_drop[p]);

        assert_boundary_frame_accepted_R7: assert property (@(posedge clk) disable iff (rst)
            window_tick |-> !frame_drop[p]);
    end

endmodule

bind storm_limiter storm_limiter_checker #(
    .NUM_PORTS    (NUM_PORTS),
    .PRESCALE_W   (PRESCALE_W),
    .LIMIT_W      (LIMIT_W),
    .MIN_PRESCALE (MIN_PRESCALE)
) u_checker (
    .clk         (clk),
    .rst         (rst),
    .limit_en    (limit_en),
    .bcast_limit (bcast_limit),
    .mcast_limit (mcast_limit),
    .frame_valid (frame_valid),
    .frame_bcast (frame_bcast),
    .frame_mcast (frame_mcast),
    .frame_drop  (frame_drop),
    .window_tick (window_tick)
);

// File: tb/tb_storm_limiter.sv
`timescale 1ns/1ps
module tb_storm_limiter;
    localparam int NP = 4;
    localparam int PW = 19;
    localparam int LW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            limit_en = 1'b0;
    logic [PW-1:0]   prescale_cfg = '0;
    logic [NP*LW-1:0] bcast_limit = '0;
    logic [NP*LW-1:0] mcast_limit = '0;
    logic [NP-1:0]   frame_valid = '0;
    logic [NP-1:0]   frame_bcast = '0;
    logic [NP-1:0]   frame_mcast = '0;
    logic [NP-1:0]   frame_drop;

    always #5 clk = ~clk;

    storm_limiter #(.NUM_PORTS(NP)) dut (
        .clk(clk), .rst(rst), .limit_en(limit_en), .prescale_cfg(prescale_cfg),
        .bcast_limit(bcast_limit), .mcast_limit(mcast_limit),
        .frame_valid(frame_valid), .frame_bcast(frame_bcast),
        .frame_mcast(frame_mcast), .frame_drop(frame_drop)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Behavioural reference state
    int win_pos = 0;
    int used_b [NP];
    int used_m [NP];
    int nxt_pos;
    int nxt_b [NP];
    int nxt_m [NP];
    int acc [NP];

    initial begin
        for (int p = 0; p < NP; p++) begin
            used_b[p] = 0; used_m[p] = 0; nxt_b[p] = 0; nxt_m[p] = 0; acc[p] = 0;
        end
        nxt_pos = 0;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int span;
        bit tick;
        span = (prescale_cfg < 16) ? 16 : int'(prescale_cfg);
        tick = limit_en && (win_pos >= span - 1);
        nxt_pos = !limit_en ? 0 : (tick ? 0 : win_pos + 1);
        for (int p = 0; p < NP; p++) begin
            int lim_b, lim_m, cur_b, cur_m;
            bit is_b, is_m, exp_drop;
            string tag;
            lim_b = int'(bcast_limit[p*LW +: LW]);
            lim_m = int'(mcast_limit[p*LW +: LW]);
            is_b  = frame_valid[p] && frame_bcast[p];
            is_m  = frame_valid[p] && !frame_bcast[p] && frame_mcast[p];
            cur_b = tick ? 0 : used_b[p];
            cur_m = tick ? 0 : used_m[p];
            exp_drop = limit_en && ((is_b && lim_b != 0 && cur_b >= lim_b) ||
                                    (is_m && lim_m != 0 && cur_m >= lim_m));
            if (!limit_en) begin
                nxt_b[p] = 0; nxt_m[p] = 0;
            end else begin
                nxt_b[p] = cur_b + ((is_b && lim_b != 0 && !exp_drop) ? 1 : 0);
                nxt_m[p] = cur_m + ((is_m && lim_m != 0 && !exp_drop) ? 1 : 0);
            end
            if (!frame_valid[p])               tag = "R10";
            else if (!limit_en)                tag = "R6";
            else if (!is_b && !is_m)           tag = "R8";
            else if (tick)                     tag = "R7";
            else if ((is_b ? lim_b : lim_m) == 0) tag = "R5";
            else                               tag = "R4";
            check(frame_drop[p] == exp_drop, tag, int'(frame_drop[p]), int'(exp_drop));
            if (!rst && frame_valid[p] && !frame_drop[p]) acc[p]++;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            win_pos <= 0;
            for (int p = 0; p < NP; p++) begin used_b[p] <= 0; used_m[p] <= 0; end
        end else begin
            win_pos <= nxt_pos;
            for (int p = 0; p < NP; p++) begin used_b[p] <= nxt_b[p]; used_m[p] <= nxt_m[p]; end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic clear_acc();
        for (int p = 0; p < NP; p++) acc[p] = 0;
    endtask

    task automatic set_port(input int p, input bit v, input bit b, input bit m);
        frame_valid[p] = v; frame_bcast[p] = b; frame_mcast[p] = m;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        frame_valid = '1; frame_bcast = '1;
        step(5);
        rst = 1'b0;
        prescale_cfg = 19'd40;
        bcast_limit = {8'd1, 8'd5, 8'd0, 8'd3};
        mcast_limit = {8'd1, 8'd0, 8'd4, 8'd2};
        #1;
        // R1: freshly reset, nothing dropped
        check(frame_drop == '0, "R1", int'(frame_drop), 0);

        // Window 1: 40 cycles, first 39 precede the closing cycle
        set_port(0, 1, 1, 0);   // bcast, budget 3
        set_port(1, 1, 1, 0);   // bcast, budget 0
        set_port(2, 1, 0, 1);   // mcast, budget 0
        set_port(3, 1, 1, 1);   // both qualifiers, bcast budget 1
        limit_en = 1'b1;
        clear_acc();
        step(39);
        check(acc[0] == 3,  "R4", acc[0], 3);
        check(acc[1] == 39, "R5", acc[1], 39);
        check(acc[2] == 39, "R5", acc[2], 39);
        check(acc[3] == 1,  "R8", acc[3], 1);
        clear_acc();
        step(1);                // closing cycle of window 1
        check(acc[0] == 1, "R7", acc[0], 1);
        check(acc[3] == 1, "R2", acc[3], 1);

        // Window 2: classes and ports independent
        set_port(0, 1, 0, 1);
        set_port(3, 1, 0, 1);
        set_port(1, 0, 0, 0);
        set_port(2, 0, 0, 0);
        clear_acc();
        step(10);
        check(acc[0] == 2, "R9", acc[0], 2);
        check(acc[3] == 1, "R9", acc[3], 1);
        set_port(0, 1, 1, 0);
        set_port(3, 0, 0, 0);
        clear_acc();
        step(5);
        check(acc[0] == 2, "R9", acc[0], 2);

        // Disable: nothing dropped, then a fresh window
        limit_en = 1'b0;
        clear_acc();
        step(5);
        check(acc[0] == 5, "R6", acc[0], 5);
        limit_en = 1'b1;
        clear_acc();
        step(39);
        check(acc[0] == 3, "R6", acc[0], 3);

        // Prescale below the floor
        limit_en = 1'b0;
        step(1);
        prescale_cfg = 19'd5;
        set_port(1, 1, 0, 0);   // no qualifiers
        limit_en = 1'b1;
        clear_acc();
        step(15);
        check(acc[0] == 3,  "R3", acc[0], 3);
        check(acc[1] == 15, "R8", acc[1], 15);
        clear_acc();
        step(1);
        check(acc[0] == 1, "R3", acc[0], 1);

        // Mixed traffic, reference model compares every cycle
        for (int blk = 0; blk < 12; blk++) begin
            limit_en = 1'b0;
            step(1);
            prescale_cfg = PW'($urandom_range(60, 0));
            for (int p = 0; p < NP; p++) begin
                bcast_limit[p*LW +: LW] = LW'($urandom_range(6, 0));
                mcast_limit[p*LW +: LW] = LW'($urandom_range(6, 0));
            end
            limit_en = 1'b1;
            for (int c = 0; c < 180; c++) begin
                frame_valid = NP'($urandom);
                frame_bcast = NP'($urandom);
                frame_mcast = NP'($urandom);
                step(1);
            end
        end

        // Reset mid-traffic restores the reset state
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        frame_valid = '0;
        #1;
        check(frame_drop == '0, "R1", int'(frame_drop), 0);
        step(2);
        finish_run();
    end

endmodule